// File: doc/BRIEF.md
# Self-Correcting One-Hot State Register

This block holds the state of a one-hot finite state machine and repairs any single flipped flop on its own. Next to the one-hot register it keeps a shadow copy of the same state. The shadow stores the state as a binary index, together with one even-parity bit computed over that index. The one-hot code alone has a minimum distance of 2. The binary index plus parity adds enough distance that the combined code survives any single upset.

The surrounding controller computes the next state from the corrected output and presents it as a one-hot vector, along with an advance strobe. When the controller does not advance, the block reloads the corrected state into all its flops, so a repaired value is written back on the next clock edge. Three fault-injection inputs invert chosen flops as they are loaded. These inputs let a test bench reach every single-upset case through the ports.

Top module: `ohs_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads state 0 into all its flops. State 0 is one-hot bit 0, binary index 0 and parity 0. After that edge `state_fixed` equals `1` in bit 0 only and `upset` is 0, whatever `step_en`, `next_state` or the flip inputs carry.
- R2: With `step_en` high and a one-hot `next_state`, `state_fixed` equals that `next_state` after the edge.
- R3: With `step_en` low, the corrected state is reloaded, so `state_fixed` keeps its value across the edge.
- R4: At an edge out of reset, each set bit of `flip_hot` inverts the one-hot flop of the same position as it is loaded. Bit j of `flip_idx` inverts binary index bit j. `flip_par` inverts the parity flop. This applies whether or not `step_en` is high.
- R5: When the stored parity disagrees with the parity recomputed from the stored index, `state_fixed` is taken from the one-hot flops. A single inverted index or parity flop therefore leaves `state_fixed` correct, and `upset` is 1.
- R6: When the parities agree, `state_fixed` is the decoded binary index, in which index i selects one-hot bit i. A single inverted one-hot flop therefore leaves `state_fixed` correct, and `upset` is 1 because the one-hot flops differ from the decode.
- R7: With no flop inverted, `upset` is 0.
- R8: After a cycle with a single upset, an edge with all flip inputs low leaves `upset` at 0 and `state_fixed` unchanged, because the repaired value has been written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Load `next_state` when high, reload the corrected state when low |
| next_state | input | N_STATES | One-hot next state from the controller |
| flip_hot | input | N_STATES | Per-bit inversion of the one-hot flops at load |
| flip_idx | input | IDX_W | Per-bit inversion of the binary index flops at load |
| flip_par | input | 1 | Inversion of the parity flop at load |
| state_fixed | output | N_STATES | Corrected one-hot state |
| upset | output | 1 | High while the stored flops disagree |

## Verification
The bench builds the block with six states, which gives a three-bit index. This choice means the index has codes no state uses, and state 5 sets two index bits at once. Within that configuration the bench visits every state. In each state it inverts each of the six one-hot flops, the three index flops and the parity flop in turn, both while holding and while advancing. This exercises both branches of the parity selection, and the write-back cycle that follows every upset.

// File: rtl/ohs_pkg.sv
// Package: shared sizing helper for the self-correcting state register.
// Assumes at least two states.
package ohs_pkg;

    // Width of the binary index for n states, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ohs_encoder.sv
// One-hot to binary index encoder.
// Assumes the input has at most one bit set; with more bits set the result
// is the OR of their indices.
module ohs_encoder #(
    parameter int N_STATES = 8,
    parameter int IDX_W    = 3
) (
    input  logic [N_STATES-1:0] hot,
    output logic [IDX_W-1:0]    idx
);

    // Purpose: OR together the index of every set bit.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_STATES; i++) begin
            if (hot[i]) begin
                idx = idx | i[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/ohs_parity.sv
// Even parity over a vector: the output is high when an odd number of
// input bits are set, so vector plus parity carries an even count.
module ohs_parity #(
    parameter int W = 3
) (
    input  logic [W-1:0] vec,
    output logic         par
);

    // Purpose: XOR-reduce the vector.
    always_comb begin
        par = ^vec;
    end

endmodule

// File: rtl/ohs_decoder.sv
// Binary index to one-hot decoder.
// Assumes nothing about the index: codes at or above N_STATES decode to zero.
module ohs_decoder #(
    parameter int N_STATES = 8,
    parameter int IDX_W    = 3
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [N_STATES-1:0] hot
);

    // Purpose: raise the one output bit whose position equals the index.
    always_comb begin
        for (int i = 0; i < N_STATES; i++) begin
            hot[i] = (idx == i[IDX_W-1:0]);
        end
    end

endmodule

// File: rtl/ohs_corrector.sv
// Chooses the trusted copy of the state.
// On a parity mismatch the shadow is suspect and the one-hot flops are used.
// On a match the decoded shadow is used. Assumes at most one flop in error.
module ohs_corrector #(
    parameter int N_STATES = 8
) (
    input  logic [N_STATES-1:0] hot_q,
    input  logic [N_STATES-1:0] dec_hot,
    input  logic                par_q,
    input  logic                par_chk,
    output logic [N_STATES-1:0] fixed,
    output logic                upset
);

    logic par_bad;

    // Purpose: compare stored and recomputed parity.
    always_comb begin
        par_bad = par_q ^ par_chk;
    end

    // Purpose: select the corrected state and raise the upset flag.
    always_comb begin
        fixed = par_bad ? hot_q : dec_hot;
        upset = par_bad | (hot_q != dec_hot);
    end

endmodule

// File: rtl/ohs_guard.sv
// Top: one-hot state register protected by a binary index plus parity shadow.
// The value loaded into every flop is either next_state (step_en high) or the
// corrected state (step_en low), so a repair is written back on the next edge.
// Assumes next_state is one-hot and at most one flop is upset at a time.
module ohs_guard #(
    parameter int N_STATES = 8,
    parameter int IDX_W    = ohs_pkg::idx_width(N_STATES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic [N_STATES-1:0] next_state,
    input  logic [N_STATES-1:0] flip_hot,
    input  logic [IDX_W-1:0]    flip_idx,
    input  logic                flip_par,
    output logic [N_STATES-1:0] state_fixed,
    output logic                upset
);

    localparam logic [N_STATES-1:0] HOT_RESET = N_STATES'(1);
    localparam int                  FLIP_W    = N_STATES + IDX_W + 1;

    logic [N_STATES-1:0] load_hot;
    logic [IDX_W-1:0]    load_idx;
    logic                load_par;
    logic [N_STATES-1:0] hot_q;
    logic [IDX_W-1:0]    idx_q;
    logic                par_q;
    logic                par_chk;
    logic [N_STATES-1:0] dec_hot;
    logic [FLIP_W-1:0]   flips;

    // Purpose: choose the value to load, which is a new state or a write-back.
    always_comb begin
        load_hot = step_en ? next_state : state_fixed;
        flips    = {flip_hot, flip_idx, flip_par};
    end

    ohs_encoder #(.N_STATES(N_STATES), .IDX_W(IDX_W)) i_enc (
        .hot (load_hot),
        .idx (load_idx)
    );

    ohs_parity #(.W(IDX_W)) i_par_gen (
        .vec (load_idx),
        .par (load_par)
    );

    // Purpose: state flops with synchronous reset and load-time fault injection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= HOT_RESET;
            idx_q <= '0;
            par_q <= 1'b0;
        end else begin
            hot_q <= load_hot ^ flip_hot;
            idx_q <= load_idx ^ flip_idx;
            par_q <= load_par ^ flip_par;
        end
    end

    ohs_parity #(.W(IDX_W)) i_par_chk (
        .vec (idx_q),
        .par (par_chk)
    );

    ohs_decoder #(.N_STATES(N_STATES), .IDX_W(IDX_W)) i_dec (
        .idx (idx_q),
        .hot (dec_hot)
    );

    ohs_corrector #(.N_STATES(N_STATES)) i_fix (
        .hot_q   (hot_q),
        .dec_hot (dec_hot),
        .par_q   (par_q),
        .par_chk (par_chk),
        .fixed   (state_fixed),
        .upset   (upset)
    );

    // R1: reset yields state 0 with a clean flag.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (state_fixed == HOT_RESET && !upset));

    // R2: an advance with a legal next state, even under one upset, shows that state.
    a_r2_load_next: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && $countones(next_state) == 1 && $countones(flips) <= 1)
        |=> state_fixed == $past(next_state));

    // R3: holding keeps the corrected state across the edge.
    a_r3_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && $countones(flips) <= 1) |=> $stable(state_fixed));

    // R5 / R6: any single injected inversion is flagged.
    a_r6_single_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(flips) == 1) |=> upset);

    // R7 / R8: with nothing injected the flops agree after the edge.
    a_r8_repaired: assert property (@(posedge clk) disable iff (!rst_n)
        (flips == '0) |=> !upset);

    // R6: the corrected output is always a single hot bit under single faults.
    a_r6_output_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(flips) <= 1 && (!step_en || $countones(next_state) == 1))
        |=> $countones(state_fixed) == 1);

endmodule

// File: tb/test_ohs_guard.sv
// Bench: behavioural golden state index compared with the outputs every cycle.
module test_ohs_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 6;
    localparam int WB         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0;
    logic [NS-1:0] next_state = '0;
    logic [NS-1:0] flip_hot = '0;
    logic [WB-1:0] flip_idx = '0;
    logic          flip_par = 1'b0;
    logic [NS-1:0] state_fixed;
    logic          upset;

    int   n_chk = 0;
    int   n_fail = 0;
    int   gold = 0;
    logic exp_up = 1'b0;
    bit   done = 1'b0;

    ohs_guard #(.N_STATES(NS), .IDX_W(WB)) i_ohs_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .next_state  (next_state),
        .flip_hot    (flip_hot),
        .flip_idx    (flip_idx),
        .flip_par    (flip_par),
        .state_fixed (state_fixed),
        .upset       (upset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One cycle: drive at the falling edge, advance the model at the rising
    // edge, compare a quarter period later.
    task automatic cycle(input logic rst_v, input logic step_v, input int nxt,
                         input logic [NS-1:0] fh, input logic [WB-1:0] fi,
                         input logic fp, input string req);
        logic [NS-1:0] exp_hot;
        @(negedge clk);
        rst_n      = rst_v;
        step_en    = step_v;
        next_state = '0;
        next_state[nxt] = 1'b1;
        flip_hot   = fh;
        flip_idx   = fi;
        flip_par   = fp;
        @(posedge clk);
        if (!rst_v) begin
            gold   = 0;
            exp_up = 1'b0;
        end else begin
            if (step_v) gold = nxt;
            exp_up = (fh != '0) || (fi != '0) || fp;
        end
        #(CLK_PERIOD/4);
        exp_hot = '0;
        exp_hot[gold] = 1'b1;
        n_chk++;
        if (state_fixed !== exp_hot) begin
            n_fail++;
            $display("FAIL %s state_fixed: actual %b expected %b", req, state_fixed, exp_hot);
        end
        n_chk++;
        if (upset !== exp_up) begin
            n_fail++;
            $display("FAIL %s upset: actual %b expected %b", req, upset, exp_up);
        end
    endtask

    initial begin
        // R1: reset ignores advance and flips.
        cycle(1'b0, 1'b1, 3, '1, '1, 1'b1, "R1");
        cycle(1'b0, 1'b1, 5, '1, '1, 1'b1, "R1");
        // R2 R7: walk through every state cleanly.
        for (int s = 1; s < NS; s++) cycle(1'b1, 1'b1, s, '0, '0, 1'b0, "R2 R7");
        cycle(1'b1, 1'b1, 0, '0, '0, 1'b0, "R2 R7");
        // R3: hold with a different next_state presented.
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 4, '0, '0, 1'b0, "R3");
        // Fault sweep in every state.
        for (int s = 0; s < NS; s++) begin
            cycle(1'b1, 1'b1, s, '0, '0, 1'b0, "R2");
            for (int b = 0; b < NS; b++) begin
                cycle(1'b1, 1'b0, s, NS'(1) << b, '0, 1'b0, "R6");
                cycle(1'b1, 1'b0, s, '0, '0, 1'b0, "R8");
            end
            for (int b = 0; b < WB; b++) begin
                cycle(1'b1, 1'b0, s, '0, WB'(1) << b, 1'b0, "R5");
                cycle(1'b1, 1'b0, s, '0, '0, 1'b0, "R8");
            end
            cycle(1'b1, 1'b0, s, '0, '0, 1'b1, "R5");
            cycle(1'b1, 1'b0, s, '0, '0, 1'b0, "R8");
            // R4: injection while advancing to the next state.
            for (int b = 0; b < NS; b++) begin
                cycle(1'b1, 1'b1, (s + b + 1) % NS, NS'(1) << b, '0, 1'b0, "R4 R6");
                cycle(1'b1, 1'b0, 0, '0, '0, 1'b0, "R8");
            end
            for (int b = 0; b < WB; b++) begin
                cycle(1'b1, 1'b1, (s + b + 2) % NS, '0, WB'(1) << b, 1'b0, "R4 R5");
                cycle(1'b1, 1'b0, 0, '0, '0, 1'b0, "R8");
            end
            cycle(1'b1, 1'b1, (s + 3) % NS, '0, '0, 1'b1, "R4 R5");
            cycle(1'b1, 1'b0, 0, '0, '0, 1'b0, "R8");
        end
        // R1: reset again from a non-zero state.
        cycle(1'b1, 1'b1, 4, '0, '0, 1'b0, "R2");
        cycle(1'b0, 1'b0, 2, '0, '1, 1'b0, "R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule